// File: doc/BRIEF.md
# Dual-Compare PWM Timer Counter

This block is a register-programmed up-counter that advances on a count-clock enable pulse, a single-cycle strobe in the system clock domain. Two compare values are held: a match on the first raises a compare-A flag and drives the PWM output high. A match on the second raises a compare-B flag, drives the PWM output low and returns the counter to zero. The compare-B value therefore sets the period, and the gap between the two values sets the duty.

Software starts and stops the counter, and requests a clear, through one control register. These requests do not act at the bus write. They are held as pending and act on the next count-clock enable pulse. While a request is pending, a busy status bit reads 1, and further control writes are dropped. The two match flags are sticky. Each is cleared by writing 1 to its bit. They are masked by per-source enables into one interrupt line.

Top module: `pwm_dual_timer`

## Requirements
- R1: After reset, every register reads 0, `pwm_out` is 0 and `irq` is 0.
- R2: A write to the control word (address 0; bit 0 run, bit 1 clear request, bit 2 busy, read-only) while busy is 0 sets busy to 1. On the next cycle with `cnt_en` high, the request takes effect and busy returns to 0. No counting happens on that cycle.
- R3: A control write made while busy reads 1 has no effect.
- R4: The clear-request bit reads 1 until the enable pulse that applies it. On that pulse the counter becomes 0 and the bit reads 0.
- R5: While running, each `cnt_en` pulse that applies no request adds 1 to the counter. A read of address 3 returns the whole 16-bit count in one word.
- R6: Stopping leaves the count unchanged, and `cnt_en` pulses have no effect while stopped. A later run continues from the held count.
- R7: On a counting pulse with the count equal to compare B (address 2), the counter becomes 0.
- R8: A control write with run and clear both set gives count 0 with run active. Counting starts on the pulses after that.
- R9: Flag bits (address 4; bit 0 compare A, bit 1 compare B) set on a counting pulse whose count equals compare A (address 1) or compare B. Writing 1 clears a flag. A set in the same cycle as a clear wins.
- R10: `irq` is 1 one cycle after any flag is set whose enable bit (address 5, same bit positions) is 1, and 0 otherwise.
- R11: `pwm_out` goes to 1 after a compare-A counting pulse and to 0 after a compare-B pulse. Compare B wins when both match. It is 0 one cycle after the counter is stopped or cleared.
- R12: A read strobe at an address returns that register on `bus_rdata` one cycle later. The compare registers and the enable register read back what was written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_en | input | 1 | Count-clock enable pulse |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 3 | Register word address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, one cycle after the strobe |
| pwm_out | output | 1 | PWM waveform |
| irq | output | 1 | Masked OR of the match flags |

## Verification
Two events can fall in the same cycle: a match flag setting on a counting pulse, and software clearing that same flag with a write-1. The bench provokes this by putting a flag-clear write and an enable pulse into one cycle while the count sits on compare A. It then judges that the flag reads back set. A second collision, compare A equal to compare B, arises in the randomized phase. There, the behavioural model requires the period-end low level on `pwm_out` to win over the high level from compare A.

// File: rtl/pwmt_pkg.sv
package pwmt_pkg;
  localparam int ADR_CTRL  = 0;
  localparam int ADR_CMPA  = 1;
  localparam int ADR_CMPB  = 2;
  localparam int ADR_COUNT = 3;
  localparam int ADR_FLAG  = 4;
  localparam int ADR_IEN   = 5;

  localparam int CB_RUN  = 0;
  localparam int CB_CLR  = 1;
  localparam int CB_BUSY = 2;

  localparam int NSRC  = 2;
  localparam int SRC_A = 0;
  localparam int SRC_B = 1;
endpackage

// File: rtl/pwmt_ctrl.sv
module pwmt_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic cnt_en,
  input  logic wr,
  input  logic wr_run,
  input  logic wr_clr,
  output logic run,
  output logic clr_pend,
  output logic busy,
  output logic apply,
  output logic clr
);
  logic run_pend;

  assign apply = busy & cnt_en;
  assign clr   = apply & clr_pend;

  always_ff @(posedge clk) begin
    if (rst) begin
      run      <= 1'b0;
      run_pend <= 1'b0;
      clr_pend <= 1'b0;
      busy     <= 1'b0;
    end else if (apply) begin
      run      <= run_pend;
      clr_pend <= 1'b0;
      busy     <= 1'b0;
    end else if (wr && !busy) begin
      run_pend <= wr_run;
      clr_pend <= wr_clr;
      busy     <= 1'b1;
    end
  end

  // R2: a pending request is consumed by the enable pulse
  a_r2_busy_done: assert property (@(posedge clk) disable iff (rst)
    busy && cnt_en |=> !busy);
  // R3: writes while busy leave the pending request untouched
  a_r3_busy_ignore: assert property (@(posedge clk) disable iff (rst)
    busy && !cnt_en |=> busy && $stable(run_pend) && $stable(clr_pend));
  // R4: clear request self-clears when applied
  a_r4_clr_selfclear: assert property (@(posedge clk) disable iff (rst)
    apply |=> !clr_pend);
endmodule

// File: rtl/pwmt_core.sv
module pwmt_core #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cnt_en,
  input  logic          run,
  input  logic          apply,
  input  logic          clr,
  input  logic [CW-1:0] cmp_a,
  input  logic [CW-1:0] cmp_b,
  output logic [CW-1:0] count,
  output logic          hit_a,
  output logic          hit_b,
  output logic          pwm
);
  logic step;

  assign step  = cnt_en & run & ~apply;
  assign hit_a = step & (count == cmp_a);
  assign hit_b = step & (count == cmp_b);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      count <= '0;
    end else if (step) begin
      count <= hit_b ? '0 : count + CW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clr || !run) begin
      pwm <= 1'b0;
    end else if (hit_b) begin
      pwm <= 1'b0;
    end else if (hit_a) begin
      pwm <= 1'b1;
    end
  end

  // R5: one increment per counting pulse below the period end
  a_r5_step: assert property (@(posedge clk) disable iff (rst)
    step && !hit_b |=> count == $past(count) + CW'(1));
  // R6: count frozen while stopped
  a_r6_hold: assert property (@(posedge clk) disable iff (rst)
    !run && !clr |=> $stable(count));
  // R7: wrap on compare B
  a_r7_wrap: assert property (@(posedge clk) disable iff (rst)
    hit_b |=> count == '0);
  // R11: output low while stopped, high after a lone compare-A match
  a_r11_stop_low: assert property (@(posedge clk) disable iff (rst)
    !run |=> !pwm);
  a_r11_rise: assert property (@(posedge clk) disable iff (rst)
    hit_a && !hit_b |=> pwm);
endmodule

// File: rtl/pwmt_irq.sv
module pwmt_irq #(
  parameter int NS = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [NS-1:0] set,
  input  logic          clr_wr,
  input  logic [NS-1:0] clr_mask,
  input  logic          ien_wr,
  input  logic [NS-1:0] ien_data,
  output logic [NS-1:0] flags,
  output logic [NS-1:0] ien,
  output logic          irq
);
  for (genvar i = 0; i < NS; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst) begin
        flags[i] <= 1'b0;
      end else if (set[i]) begin
        flags[i] <= 1'b1;
      end else if (clr_wr && clr_mask[i]) begin
        flags[i] <= 1'b0;
      end
    end

    // R9: a match always leaves its flag set
    a_r9_set_wins: assert property (@(posedge clk) disable iff (rst)
      set[i] |=> flags[i]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ien <= '0;
    end else if (ien_wr) begin
      ien <= ien_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= |(flags & ien);
  end

  // R10: interrupt tracks enabled flags one cycle later
  a_r10_irq_on: assert property (@(posedge clk) disable iff (rst)
    |(flags & ien) |=> irq);
  a_r10_irq_off: assert property (@(posedge clk) disable iff (rst)
    !(|(flags & ien)) |=> !irq);
endmodule

// File: rtl/pwm_dual_timer.sv
module pwm_dual_timer #(
  parameter int CW = 16,
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cnt_en,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [AW-1:0] bus_addr,
  input  logic [CW-1:0] bus_wdata,
  output logic [CW-1:0] bus_rdata,
  output logic          pwm_out,
  output logic          irq
);
  import pwmt_pkg::*;

  localparam int NS = NSRC;

  logic          sel_ctrl, sel_a, sel_b, sel_flag, sel_ien;
  logic          run, clr_pend, busy, apply, clr;
  logic [CW-1:0] cmp_a, cmp_b, count;
  logic          hit_a, hit_b;
  logic [NS-1:0] set, flags, ien;

  assign sel_ctrl = bus_wr && (bus_addr == AW'(ADR_CTRL));
  assign sel_a    = bus_wr && (bus_addr == AW'(ADR_CMPA));
  assign sel_b    = bus_wr && (bus_addr == AW'(ADR_CMPB));
  assign sel_flag = bus_wr && (bus_addr == AW'(ADR_FLAG));
  assign sel_ien  = bus_wr && (bus_addr == AW'(ADR_IEN));

  always_ff @(posedge clk) begin
    if (rst) begin
      cmp_a <= '0;
      cmp_b <= '0;
    end else begin
      if (sel_a) cmp_a <= bus_wdata;
      if (sel_b) cmp_b <= bus_wdata;
    end
  end

  pwmt_ctrl u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .cnt_en  (cnt_en),
    .wr      (sel_ctrl),
    .wr_run  (bus_wdata[CB_RUN]),
    .wr_clr  (bus_wdata[CB_CLR]),
    .run     (run),
    .clr_pend(clr_pend),
    .busy    (busy),
    .apply   (apply),
    .clr     (clr)
  );

  pwmt_core #(.CW(CW)) u_core (
    .clk   (clk),
    .rst   (rst),
    .cnt_en(cnt_en),
    .run   (run),
    .apply (apply),
    .clr   (clr),
    .cmp_a (cmp_a),
    .cmp_b (cmp_b),
    .count (count),
    .hit_a (hit_a),
    .hit_b (hit_b),
    .pwm   (pwm_out)
  );

  always_comb begin
    set        = '0;
    set[SRC_A] = hit_a;
    set[SRC_B] = hit_b;
  end

  pwmt_irq #(.NS(NS)) u_irq (
    .clk     (clk),
    .rst     (rst),
    .set     (set),
    .clr_wr  (sel_flag),
    .clr_mask(bus_wdata[NS-1:0]),
    .ien_wr  (sel_ien),
    .ien_data(bus_wdata[NS-1:0]),
    .flags   (flags),
    .ien     (ien),
    .irq     (irq)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_rd) begin
      bus_rdata <= '0;
      case (bus_addr)
        AW'(ADR_CTRL): begin
          bus_rdata[CB_RUN]  <= run;
          bus_rdata[CB_CLR]  <= clr_pend;
          bus_rdata[CB_BUSY] <= busy;
        end
        AW'(ADR_CMPA):  bus_rdata <= cmp_a;
        AW'(ADR_CMPB):  bus_rdata <= cmp_b;
        AW'(ADR_COUNT): bus_rdata <= count;
        AW'(ADR_FLAG):  bus_rdata[NS-1:0] <= flags;
        AW'(ADR_IEN):   bus_rdata[NS-1:0] <= ien;
        default:        bus_rdata <= '0;
      endcase
    end
  end

  // R12: read data only changes after a read strobe
  a_r12_rdata_hold: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> $stable(bus_rdata));
endmodule

// File: tb/pwm_dual_timer_bench.sv
module pwm_dual_timer_bench;
  timeunit 1ns;
  timeprecision 1ps;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cnt_en = 1'b0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        pwm_out;
  logic        irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  pwm_dual_timer u_pwm_dual_timer (
    .clk(clk), .rst(rst), .cnt_en(cnt_en), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pwm_out(pwm_out), .irq(irq)
  );

  // behavioural reference
  int m_run, m_prun, m_prst, m_busy, m_cnt, m_a, m_b, m_fl, m_ien, m_pwm, m_irq, m_rd;
  int last_addr;

  always @(posedge clk) begin
    int n_irq, n_pwm, n_cnt, n_fl;
    bit app, stp, sa, sb, do_clr;
    if (rst) begin
      m_run = 0; m_prun = 0; m_prst = 0; m_busy = 0; m_cnt = 0; m_a = 0; m_b = 0;
      m_fl = 0; m_ien = 0; m_pwm = 0; m_irq = 0; m_rd = 0; last_addr = 0;
    end else begin
      n_irq = ((m_fl & m_ien) != 0) ? 1 : 0;
      if (bus_rd) begin
        last_addr = int'(bus_addr);
        case (int'(bus_addr))
          0: m_rd = m_busy * 4 + m_prst * 2 + m_run;
          1: m_rd = m_a;
          2: m_rd = m_b;
          3: m_rd = m_cnt;
          4: m_rd = m_fl;
          5: m_rd = m_ien;
          default: m_rd = 0;
        endcase
      end
      app = cnt_en && (m_busy != 0);
      stp = cnt_en && (m_run != 0) && !app;
      sa = stp && (m_cnt == m_a);
      sb = stp && (m_cnt == m_b);
      do_clr = app && (m_prst != 0);
      n_pwm = (m_run != 0) ? m_pwm : 0;
      if (do_clr) n_pwm = 0;
      else if (sb) n_pwm = 0;
      else if (sa) n_pwm = 1;
      n_cnt = m_cnt;
      if (do_clr) n_cnt = 0;
      else if (stp) n_cnt = (m_cnt == m_b) ? 0 : ((m_cnt + 1) & 16'hFFFF);
      n_fl = m_fl;
      if (bus_wr && bus_addr == 3'd4) n_fl = n_fl & ~int'(bus_wdata);
      if (sa) n_fl = n_fl | 1;
      if (sb) n_fl = n_fl | 2;
      n_fl = n_fl & 3;
      if (app) begin
        m_run = m_prun; m_prst = 0; m_busy = 0;
      end else if (bus_wr && bus_addr == 3'd0 && m_busy == 0) begin
        m_prun = int'(bus_wdata[0]); m_prst = int'(bus_wdata[1]); m_busy = 1;
      end
      if (bus_wr && bus_addr == 3'd1) m_a = int'(bus_wdata);
      if (bus_wr && bus_addr == 3'd2) m_b = int'(bus_wdata);
      if (bus_wr && bus_addr == 3'd5) m_ien = int'(bus_wdata) & 3;
      m_irq = n_irq; m_pwm = n_pwm; m_cnt = n_cnt; m_fl = n_fl;
    end
  end

  task automatic chk(input int act, input int exp, input string tag);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // per-clock comparison against the model
  always @(posedge clk) begin
    #1;
    if (!rst && !done) begin
      chk(int'(pwm_out), m_pwm, "R11 pwm_out vs model");
      chk(int'(irq), m_irq, "R10 irq vs model");
      case (last_addr)
        0: chk(int'(bus_rdata), m_rd, "R2 control readback vs model");
        3: chk(int'(bus_rdata), m_rd, "R5 count readback vs model");
        4: chk(int'(bus_rdata), m_rd, "R9 flag readback vs model");
        default: chk(int'(bus_rdata), m_rd, "R12 register readback vs model");
      endcase
    end
  end

  task automatic step(input bit en, input bit wr, input bit rd, input int adr, input int dat);
    @(negedge clk);
    cnt_en = en; bus_wr = wr; bus_rd = rd;
    bus_addr = 3'(adr); bus_wdata = 16'(dat);
    @(posedge clk);
    #2;
  endtask

  task automatic wreg(input int adr, input int dat);
    step(1'b0, 1'b1, 1'b0, adr, dat);
  endtask

  task automatic pulse(input int n);
    for (int i = 0; i < n; i++) step(1'b1, 1'b0, 1'b0, 0, 0);
  endtask

  task automatic rchk(input int adr, input int exp, input string tag);
    step(1'b0, 1'b0, 1'b1, adr, 0);
    chk(int'(bus_rdata), exp, tag);
  endtask

  initial begin
    #2_000_000;
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    rchk(0, 0, "R1 control after reset");
    rchk(3, 0, "R1 count after reset");
    chk(int'(pwm_out), 0, "R1 pwm after reset");
    chk(int'(irq), 0, "R1 irq after reset");

    wreg(1, 2); wreg(2, 5); wreg(5, 3);
    rchk(1, 2, "R12 compare A readback");
    wreg(0, 3);
    rchk(0, 6, "R2 R4 busy and pending clear");
    wreg(0, 0);
    pulse(1);
    rchk(0, 1, "R3 ignored write, R8 running after clear");
    rchk(3, 0, "R8 count zero after run+clear");

    pulse(3);
    chk(int'(pwm_out), 1, "R11 high after compare A");
    rchk(3, 3, "R5 three counts");
    rchk(4, 1, "R9 compare A flag");
    chk(int'(irq), 1, "R10 irq with enabled flag");

    pulse(3);
    rchk(3, 0, "R7 wrap at compare B");
    chk(int'(pwm_out), 0, "R11 low after compare B");
    rchk(4, 3, "R9 both flags");
    wreg(4, 3);
    rchk(4, 0, "R9 write-1 clear");
    chk(int'(irq), 0, "R10 irq low after clear");

    pulse(2);
    step(1'b1, 1'b1, 1'b0, 4, 1);
    rchk(4, 1, "R9 set wins over clear");

    wreg(0, 0);
    pulse(3);
    chk(int'(pwm_out), 0, "R11 low when stopped");
    rchk(3, 3, "R6 count held while stopped");
    wreg(0, 1);
    pulse(2);
    rchk(3, 4, "R6 resume from held count");

    wreg(1, 5);
    pulse(2);
    rchk(3, 0, "R7 wrap with A equal B");
    chk(int'(pwm_out), 0, "R11 compare B wins over A");

    pulse(2);
    wreg(0, 3);
    pulse(1);
    rchk(0, 1, "R4 clear bit self-cleared");
    rchk(3, 0, "R4 counter cleared");

    for (int i = 0; i < 1500; i++) begin
      int r, adr, dat;
      r = int'($urandom_range(0, 11));
      adr = int'($urandom_range(0, 5));
      dat = (adr == 1 || adr == 2) ? int'($urandom_range(0, 7)) : int'($urandom_range(0, 3));
      step(r < 5, r == 5 || r == 6, r >= 9, adr, dat);
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule